// File: doc/BRIEF.md
# Dual Raw and Zero-Suppressed Sample Buffer

This block records the digitised samples of a multi-channel front end over one bunch train. Each accepted sample is written into a raw store at a slot fixed by its bunch number and channel. When its value is strictly above a programmable threshold, it is also appended to a small sparse store as a tagged record. The sparse store holds a bunch tag, a channel tag and the value. Data taking is untriggered, so every sample that arrives while the train input is high is captured.

Once the train has ended, a start pulse begins readout over a ready/valid stream. A two-bit mode picks the raw store, the sparse store, or both. Every readout begins with one header word that gives the word counts that follow. When both stores are selected, the raw words come before the sparse records. Samples that arrive during readout are not stored and set a sticky error flag.

Samples whose bunch or channel falls outside the raw store's geometry skip the raw store but are still tested against the threshold. The raw store is not cleared between trains, so a slot keeps its last written value.

Top module: `dual_sample_buffer`

## Requirements
- R1: After reset, out_valid, out_last, overflow and wr_error are 0 and sparse_count is 0.
- R2: A sample accepted while train_active is high is written to raw slot bunch*NUM_CHAN+chan. A raw readout emits every slot in order, bunch major and channel minor. Each word is kind 2'b01 in bits [32:31], with bunch in [30:19], channel in [18:12] and value in [11:0].
- R3: An accepted sample is appended to the sparse store only when in_value > thresh (a value equal to the threshold is not kept). Records leave in arrival order as kind 2'b10 with the same field positions as raw words. sparse_count shows the new count one cycle after the sample.
- R4: When sparse_count equals SPARSE_DEPTH, a further passing sample is dropped, the count stays, and overflow is set.
- R5: rd_mode bit 0 selects the raw store and bit 1 selects the sparse store. A start pulse with rd_mode 2'b00 is ignored and no word is produced.
- R6: When both stores are selected, the header is followed by all raw words and then all sparse records. out_last is high on exactly the final word of every readout.
- R7: The first word of every readout is a header of kind 2'b00. It carries the raw word count in [9:0] (0 when raw is not selected), the sparse record count in [14:10] (0 when sparse is not selected) and the overflow flag in [15]; all other bits are 0.
- R8: A sample presented while readout is in progress is not stored in either memory and sparse_count does not change. wr_error goes high one cycle later and stays high.
- R9: rd_start is ignored while train_active is high. A sample presented while train_active is low and no readout runs has no effect.
- R10: A rising edge of train_active, while no readout runs, clears sparse_count, overflow and wr_error.
- R11: While out_valid is high and out_ready is low, out_data and out_valid hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| train_active | input | 1 | High for the duration of a bunch train |
| in_valid | input | 1 | Sample present |
| in_chan | input | CHAN_W | Channel of the sample |
| in_bunch | input | BUNCH_W | Bunch number of the sample |
| in_value | input | VAL_W | Digitised value |
| thresh | input | VAL_W | Sparse threshold, strict greater-than |
| rd_mode | input | 2 | Bit 0 raw, bit 1 sparse |
| rd_start | input | 1 | Pulse that begins readout |
| out_valid | output | 1 | Stream word valid |
| out_ready | input | 1 | Consumer accepts the word |
| out_data | output | BUNCH_W+CHAN_W+VAL_W+2 | Stream word (kind in top two bits) |
| out_last | output | 1 | Final word of the readout |
| sparse_count | output | clog2(SPARSE_DEPTH+1) | Records held in the sparse store |
| overflow | output | 1 | A passing sample was dropped for lack of space |
| wr_error | output | 1 | A sample arrived during readout |

## Verification
A sample presented on a cycle is written at the next rising edge. Its effect on sparse_count, overflow and wr_error is therefore visible one cycle later, and the bench reads these flags at the falling edge after that write edge. The header word appears one cycle after the rd_start edge. Each later word appears one cycle after the previous word's handshake. A scoreboard queue is filled before the start pulse, and a monitor compares a word at the falling edge only when out_valid and its own out_ready are both high, so backpressure never shifts the comparison. Data integrity after rejected or ignored samples is confirmed by reading the stores back through the stream.

// File: rtl/dsb_pkg.sv
package dsb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HDR  = 2'd1,
        ST_RAW  = 2'd2,
        ST_SPR  = 2'd3
    } dsb_state_e;

    localparam logic [1:0] KIND_HDR = 2'b00;
    localparam logic [1:0] KIND_RAW = 2'b01;
    localparam logic [1:0] KIND_SPR = 2'b10;

endpackage

// File: rtl/dsb_store.sv
module dsb_store #(
    parameter int DEPTH = 16,
    parameter int W     = 12,
    parameter int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/dsb_fmt.sv
module dsb_fmt
    import dsb_pkg::*;
#(
    parameter int BUNCH_W   = 12,
    parameter int CHAN_W    = 7,
    parameter int VAL_W     = 12,
    parameter int RAW_DEPTH = 512,
    parameter int SC_W      = 5,
    localparam int PAY_W    = BUNCH_W + CHAN_W + VAL_W,
    localparam int RC_W     = $clog2(RAW_DEPTH + 1)
) (
    input  dsb_state_e         st,
    input  logic [1:0]         mode,
    input  logic [BUNCH_W-1:0] raw_bunch,
    input  logic [CHAN_W-1:0]  raw_chan,
    input  logic [VAL_W-1:0]   raw_val,
    input  logic [PAY_W-1:0]   sp_rec,
    input  logic [SC_W-1:0]    scnt,
    input  logic               ovf,
    output logic [PAY_W+1:0]   word
);
    logic [PAY_W-1:0] hdr;

    always_comb begin
        hdr = '0;
        if (mode[0]) begin
            hdr[RC_W-1:0] = RC_W'(RAW_DEPTH);
        end
        if (mode[1]) begin
            hdr[RC_W +: SC_W] = scnt;
        end
        hdr[RC_W+SC_W] = ovf;

        case (st)
            ST_HDR:  word = {KIND_HDR, hdr};
            ST_RAW:  word = {KIND_RAW, raw_bunch, raw_chan, raw_val};
            ST_SPR:  word = {KIND_SPR, sp_rec};
            default: word = '0;
        endcase
    end

endmodule

// File: rtl/dual_sample_buffer.sv
module dual_sample_buffer
    import dsb_pkg::*;
#(
    parameter int NUM_BUNCH    = 32,
    parameter int NUM_CHAN     = 16,
    parameter int SPARSE_DEPTH = 16,
    parameter int BUNCH_W      = 12,
    parameter int CHAN_W       = 7,
    parameter int VAL_W        = 12
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 train_active,
    input  logic                                 in_valid,
    input  logic [CHAN_W-1:0]                    in_chan,
    input  logic [BUNCH_W-1:0]                   in_bunch,
    input  logic [VAL_W-1:0]                     in_value,
    input  logic [VAL_W-1:0]                     thresh,
    input  logic [1:0]                           rd_mode,
    input  logic                                 rd_start,
    output logic                                 out_valid,
    input  logic                                 out_ready,
    output logic [BUNCH_W+CHAN_W+VAL_W+1:0]      out_data,
    output logic                                 out_last,
    output logic [$clog2(SPARSE_DEPTH+1)-1:0]    sparse_count,
    output logic                                 overflow,
    output logic                                 wr_error
);
    localparam int RAW_DEPTH = NUM_BUNCH * NUM_CHAN;
    localparam int RAW_AW    = (RAW_DEPTH > 1) ? $clog2(RAW_DEPTH) : 1;
    localparam int SP_AW     = (SPARSE_DEPTH > 1) ? $clog2(SPARSE_DEPTH) : 1;
    localparam int SC_W      = $clog2(SPARSE_DEPTH + 1);
    localparam int RB_W      = (NUM_BUNCH > 1) ? $clog2(NUM_BUNCH) : 1;
    localparam int RCH_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;
    localparam int PAY_W     = BUNCH_W + CHAN_W + VAL_W;

    typedef struct packed {
        dsb_state_e       st;
        logic [1:0]       mode;
        logic [RB_W-1:0]  rb;
        logic [RCH_W-1:0] rc;
        logic [SP_AW-1:0] sidx;
        logic [SC_W-1:0]  scnt;
        logic             ovf;
        logic             werr;
        logic             train;
    } state_t;

    state_t q, d;

    logic              busy, rise, cap, pass, in_range, sp_full;
    logic              raw_we, sp_we, fire, sp_follow, raw_end, sp_end, last;
    logic [RAW_AW-1:0] raw_waddr, raw_raddr;
    logic [SP_AW-1:0]  sp_waddr;
    logic [VAL_W-1:0]  raw_rdata;
    logic [PAY_W-1:0]  sp_rdata;

    always_comb begin
        d         = q;
        d.train   = train_active;
        busy      = (q.st != ST_IDLE);
        rise      = train_active & ~q.train;

        if (rise && !busy) begin
            d.scnt = '0;
            d.ovf  = 1'b0;
            d.werr = 1'b0;
        end

        // capture path
        cap       = in_valid & train_active & ~busy;
        pass      = (in_value > thresh);
        in_range  = ({1'b0, in_bunch} < (BUNCH_W+1)'(NUM_BUNCH)) &&
                    ({1'b0, in_chan}  < (CHAN_W+1)'(NUM_CHAN));
        raw_we    = cap & in_range;
        raw_waddr = RAW_AW'(in_bunch) * RAW_AW'(NUM_CHAN) + RAW_AW'(in_chan);
        sp_full   = (d.scnt == SC_W'(SPARSE_DEPTH));
        sp_we     = cap & pass & ~sp_full;
        sp_waddr  = SP_AW'(d.scnt);
        if (sp_we) begin
            d.scnt = d.scnt + SC_W'(1);
        end
        if (cap && pass && sp_full) begin
            d.ovf = 1'b1;
        end
        if (in_valid && busy) begin
            d.werr = 1'b1;
        end

        // readout path
        fire      = busy & out_ready;
        sp_follow = q.mode[1] & (q.scnt != '0);
        raw_end   = (q.rb == RB_W'(NUM_BUNCH - 1)) && (q.rc == RCH_W'(NUM_CHAN - 1));
        sp_end    = ((SC_W'(q.sidx) + SC_W'(1)) == q.scnt);
        raw_raddr = RAW_AW'(q.rb) * RAW_AW'(NUM_CHAN) + RAW_AW'(q.rc);

        case (q.st)
            ST_HDR:  last = ~q.mode[0] & ~sp_follow;
            ST_RAW:  last = raw_end & ~sp_follow;
            ST_SPR:  last = sp_end;
            default: last = 1'b0;
        endcase

        case (q.st)
            ST_IDLE: begin
                if (rd_start && !train_active && (rd_mode != 2'b00)) begin
                    d.st   = ST_HDR;
                    d.mode = rd_mode;
                    d.rb   = '0;
                    d.rc   = '0;
                    d.sidx = '0;
                end
            end
            ST_HDR: begin
                if (fire) begin
                    if (q.mode[0])      d.st = ST_RAW;
                    else if (sp_follow) d.st = ST_SPR;
                    else                d.st = ST_IDLE;
                end
            end
            ST_RAW: begin
                if (fire) begin
                    if (raw_end) begin
                        d.st = sp_follow ? ST_SPR : ST_IDLE;
                    end else if (q.rc == RCH_W'(NUM_CHAN - 1)) begin
                        d.rc = '0;
                        d.rb = q.rb + RB_W'(1);
                    end else begin
                        d.rc = q.rc + RCH_W'(1);
                    end
                end
            end
            ST_SPR: begin
                if (fire) begin
                    if (sp_end) d.st = ST_IDLE;
                    else        d.sidx = q.sidx + SP_AW'(1);
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, mode: 2'b00, rb: '0, rc: '0, sidx: '0,
                   scnt: '0, ovf: 1'b0, werr: 1'b0, train: 1'b0};
        end else begin
            q <= d;
        end
    end

    dsb_store #(.DEPTH(RAW_DEPTH), .W(VAL_W), .AW(RAW_AW)) u_raw (
        .clk   (clk),
        .we    (raw_we),
        .waddr (raw_waddr),
        .wdata (in_value),
        .raddr (raw_raddr),
        .rdata (raw_rdata)
    );

    dsb_store #(.DEPTH(SPARSE_DEPTH), .W(PAY_W), .AW(SP_AW)) u_sparse (
        .clk   (clk),
        .we    (sp_we),
        .waddr (sp_waddr),
        .wdata ({in_bunch, in_chan, in_value}),
        .raddr (q.sidx),
        .rdata (sp_rdata)
    );

    dsb_fmt #(
        .BUNCH_W(BUNCH_W), .CHAN_W(CHAN_W), .VAL_W(VAL_W),
        .RAW_DEPTH(RAW_DEPTH), .SC_W(SC_W)
    ) u_fmt (
        .st        (q.st),
        .mode      (q.mode),
        .raw_bunch (BUNCH_W'(q.rb)),
        .raw_chan  (CHAN_W'(q.rc)),
        .raw_val   (raw_rdata),
        .sp_rec    (sp_rdata),
        .scnt      (q.scnt),
        .ovf       (q.ovf),
        .word      (out_data)
    );

    assign out_valid    = busy;
    assign out_last     = busy & last;
    assign sparse_count = q.scnt;
    assign overflow     = q.ovf;
    assign wr_error     = q.werr;

endmodule

// File: rtl/dsb_checker.sv
module dsb_checker #(
    parameter int DATA_W       = 33,
    parameter int SC_W         = 5,
    parameter int SPARSE_DEPTH = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              train_active,
    input logic              in_valid,
    input logic              rd_start,
    input logic [1:0]        rd_mode,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic [SC_W-1:0]   sparse_count,
    input logic              overflow,
    input logic              wr_error
);
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data));

    p_cnt_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sparse_count <= SC_W'(SPARSE_DEPTH));

    p_ovf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        overflow && !train_active |=> overflow);

    p_wrerr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && out_valid |=> wr_error);

    p_cnt_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> $stable(sparse_count));

    p_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && rd_start && rd_mode == 2'b00 |=> !out_valid);

    p_no_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid && rd_start && train_active |=> !out_valid);

    p_hdr_first_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_data[DATA_W-1:DATA_W-2] == 2'b00);

    p_last_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);

endmodule

bind dual_sample_buffer dsb_checker #(
    .DATA_W(BUNCH_W + CHAN_W + VAL_W + 2),
    .SC_W($clog2(SPARSE_DEPTH + 1)),
    .SPARSE_DEPTH(SPARSE_DEPTH)
) u_chk (
    .clk(clk), .rst_n(rst_n), .train_active(train_active), .in_valid(in_valid),
    .rd_start(rd_start), .rd_mode(rd_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .sparse_count(sparse_count), .overflow(overflow), .wr_error(wr_error)
);

// File: tb/sim_dual_sample_buffer.sv
`timescale 1ns/1ps
module sim_dual_sample_buffer;
    localparam int NB = 32, NC = 16, SD = 16;

    logic        clk = 0, rst_n = 0, train_active = 0, in_valid = 0;
    logic [6:0]  in_chan = 0;
    logic [11:0] in_bunch = 0, in_value = 0, thresh = 12'd100;
    logic [1:0]  rd_mode = 0;
    logic        rd_start = 0, out_ready = 0;
    logic        out_valid, out_last, overflow, wr_error;
    logic [32:0] out_data;
    logic [4:0]  sparse_count;

    always #4 clk = ~clk;

    dual_sample_buffer u0 (
        .clk(clk), .rst_n(rst_n), .train_active(train_active), .in_valid(in_valid),
        .in_chan(in_chan), .in_bunch(in_bunch), .in_value(in_value), .thresh(thresh),
        .rd_mode(rd_mode), .rd_start(rd_start), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
        .sparse_count(sparse_count), .overflow(overflow), .wr_error(wr_error)
    );

    typedef struct { logic [32:0] d; logic last; string tag; } exp_t;
    exp_t        exp_q[$];
    int          ntests = 0, nfail = 0;
    int          raw_m [NB*NC];
    logic [30:0] sp_m[$];
    bit          ovf_m = 0, rd_busy = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        ntests++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic put(input int b, input int c, input int v);
        bit acc;
        acc = train_active && !rd_busy;
        in_valid = 1; in_bunch = 12'(b); in_chan = 7'(c); in_value = 12'(v);
        @(negedge clk);
        in_valid = 0;
        if (acc) begin
            raw_m[b*NC + c] = v;
            if (v > int'(thresh)) begin
                if (sp_m.size() < SD) sp_m.push_back({12'(b), 7'(c), 12'(v)});
                else ovf_m = 1;
            end
        end
    endtask

    // driver: fills the scoreboard, then pulses the start
    task automatic start_read(input logic [1:0] m);
        exp_t        e;
        logic [32:0] h;
        int          nsp;
        nsp = m[1] ? sp_m.size() : 0;
        h = '0;
        h[9:0]   = m[0] ? 10'(NB*NC) : 10'd0;
        h[14:10] = 5'(nsp);
        h[15]    = ovf_m;
        e.d = h; e.last = !m[0] && nsp == 0; e.tag = "R7 header";
        exp_q.push_back(e);
        if (m[0]) begin
            for (int a = 0; a < NB*NC; a++) begin
                e.d = {2'b01, 12'(a / NC), 7'(a % NC), 12'(raw_m[a])};
                e.last = (a == NB*NC-1) && nsp == 0;
                e.tag = "R2 raw word";
                exp_q.push_back(e);
            end
        end
        for (int i = 0; i < nsp; i++) begin
            e.d = {2'b10, sp_m[i]};
            e.last = (i == nsp-1);
            e.tag = "R3 sparse record";
            exp_q.push_back(e);
        end
        rd_busy = 1;
        rd_mode = m; rd_start = 1;
        @(negedge clk);
        rd_start = 0;
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        chk(out_valid == 0, "R6 stream ends after last", 64'(out_valid), 0);
        rd_busy = 0;
    endtask

    // monitor: pops and compares on each handshake
    initial begin
        int          rc = 0;
        bit          stall = 0;
        logic [32:0] pd = '0;
        exp_t        e;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                rc++;
                out_ready = (rc % 3) != 0;
                if (stall) chk(out_valid && out_data == pd, "R11 hold under backpressure", 64'(out_data), 64'(pd));
                if (out_valid && out_ready) begin
                    if (exp_q.size() == 0) begin
                        chk(0, "R6 unexpected word", 64'(out_data), 0);
                    end else begin
                        e = exp_q.pop_front();
                        chk(out_data == e.d, e.tag, 64'(out_data), 64'(e.d));
                        chk(out_last == e.last, "R6 last flag", 64'(out_last), 64'(e.last));
                    end
                end
                stall = out_valid && !out_ready;
                pd = out_data;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(out_valid == 0, "R1 out_valid", 64'(out_valid), 0);
        chk(out_last == 0, "R1 out_last", 64'(out_last), 0);
        chk(sparse_count == 0, "R1 sparse_count", 64'(sparse_count), 0);
        chk(overflow == 0 && wr_error == 0, "R1 flags", 64'({overflow, wr_error}), 0);

        // train A: fill the raw grid, a few values above threshold
        train_active = 1;
        @(negedge clk);
        for (int b = 0; b < NB; b++) begin
            for (int c = 0; c < NC; c++) begin
                int v;
                v = (b*5 + c*3) % 90;
                if (b == 0 && c == 0)   v = 101;
                if (b == 3 && c == 5)   v = 4000;
                if (b == 7 && c == 2)   v = 100;
                if (b == 8 && c == 8)   v = 99;
                if (b == 10 && c == 15) v = 150;
                if (b == 20 && c == 1)  v = 200;
                if (b == 31 && c == 15) v = 4095;
                put(b, c, v);
                if (b == 0 && c == 0)
                    chk(sparse_count == 1, "R3 count one cycle after pass", 64'(sparse_count), 1);
            end
        end
        train_active = 0;
        @(negedge clk);
        chk(sparse_count == 5, "R3 strict threshold count", 64'(sparse_count), 5);
        chk(overflow == 0, "R4 no overflow", 64'(overflow), 0);

        // R9: sample outside train and idle is ignored
        put(0, 1, 3000);
        @(negedge clk);
        chk(sparse_count == 5, "R9 idle sample ignored", 64'(sparse_count), 5);

        // R6 both stores, with a rejected sample mid-stream (R8)
        start_read(2'b11);
        repeat (5) @(negedge clk);
        put(1, 1, 4000);
        chk(wr_error == 1, "R8 wr_error set", 64'(wr_error), 1);
        chk(sparse_count == 5, "R8 count unchanged", 64'(sparse_count), 5);
        drain();
        chk(wr_error == 1, "R8 wr_error sticky", 64'(wr_error), 1);

        // R5 raw only (also proves slots (0,1) and (1,1) untouched)
        start_read(2'b01);
        drain();
        // R5 sparse only
        start_read(2'b10);
        drain();

        // R5 mode 00 ignored
        rd_mode = 2'b00; rd_start = 1;
        @(negedge clk);
        rd_start = 0;
        repeat (3) begin
            chk(out_valid == 0, "R5 mode zero ignored", 64'(out_valid), 0);
            @(negedge clk);
        end

        // train B: start pulse during train ignored (R9), clears (R10)
        train_active = 1; rd_mode = 2'b11; rd_start = 1;
        sp_m.delete(); ovf_m = 0;
        @(negedge clk);
        rd_start = 0;
        chk(out_valid == 0, "R9 start ignored in train", 64'(out_valid), 0);
        chk(sparse_count == 0, "R10 count cleared", 64'(sparse_count), 0);
        chk(wr_error == 0 && overflow == 0, "R10 flags cleared", 64'({wr_error, overflow}), 0);
        for (int i = 0; i < 20; i++) put(5 + i/NC, i % NC, 500 + i);
        train_active = 0;
        @(negedge clk);
        chk(sparse_count == 5'(SD), "R4 count saturates", 64'(sparse_count), 64'(SD));
        chk(overflow == 1, "R4 overflow set", 64'(overflow), 1);
        start_read(2'b11);
        drain();

        $display("[TB] %0d tests run, %0d failed", ntests, nfail);
        $finish;
    end
endmodule